// File: doc/BRIEF.md
# Receive-Threshold Flow-Control Character Inserter

This block watches how full the local receive FIFO is and, when flow control is switched on, pushes pause and resume characters into the outgoing serial stream. When the fill level climbs above a programmed threshold, the block queues the pause message. When the level later sinks below the threshold, it queues the resume message. A message is one character, or a pair of characters in pair mode.

The block sits between the transmit FIFO and the transmit serializer. Both sides use valid/ready streams. A character is transferred on a cycle where valid and ready are both high. Once the block raises `out_valid`, it holds `out_data` and `out_is_ctrl` unchanged until `out_ready` is seen high.

A control character is inserted only at a character boundary. A data character already on offer keeps the output until it is accepted. After that, queued control characters take precedence over further data. While a control character is on offer, `tx_ready` stays low, which back-pressures the FIFO.

Top module: `fc_xonoff_gen`

## Requirements
- R1: After reset the block is in the resumed state with nothing queued. `out_is_ctrl` is 0 and the first qualifying level rise produces a pause message.
- R2: While enabled and resumed, a level strictly greater than the threshold queues the pause message once and moves the block to the paused state.
- R3: While the level stays on one side of the threshold, or equals it, no further message is produced.
- R4: While enabled and paused, a level strictly less than the threshold queues the resume message once and moves the block to the resumed state.
- R5: In pair mode (`double_mode`=1) a message is character 1 followed by character 2 on consecutive accepted transfers, with no data between them. The mode is captured when the message is queued.
- R6: Control characters are masked to the word length. `word_len` 0 keeps 5 bits, 1 keeps 6, 2 keeps 7 and 3 keeps 8; the higher bits read as 0.
- R7: A data character already offered and not yet accepted stays on the output until accepted. After that, a queued control character is offered ahead of any further data.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_is_ctrl` stay unchanged.
- R9: Clearing `enable` returns the block to the resumed state without sending a resume message. No new message is queued while `enable` is low. A message already queued still completes.
- R10: When no control character is queued, the output carries the transmit FIFO stream unchanged, with `out_is_ctrl`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Automatic flow-control enable |
| double_mode | input | 1 | 1: two-character messages |
| word_len | input | 2 | Character length code, 0..3 = 5..8 bits |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| trigger | input | LVL_W | Threshold level |
| xoff_char1 | input | CHAR_W | Pause character 1 |
| xoff_char2 | input | CHAR_W | Pause character 2 |
| xon_char1 | input | CHAR_W | Resume character 1 |
| xon_char2 | input | CHAR_W | Resume character 2 |
| tx_valid | input | 1 | Transmit FIFO data valid |
| tx_data | input | CHAR_W | Transmit FIFO data |
| tx_ready | output | 1 | Transmit FIFO data accepted |
| out_valid | output | 1 | Character offered to serializer |
| out_data | output | CHAR_W | Offered character |
| out_is_ctrl | output | 1 | Offered character is a flow-control character |
| out_ready | input | 1 | Serializer takes the character |

## Verification
The hysteresis flag and the queued message are internal state. Errors in them show up at the output stream one cycle after the level change that should, or should not, trigger a message:
- A lost or stuck paused flag shows as a repeated pause message while the level stays high, or as a missing one.
- A wrong pair index shows as a wrong or missing second character, or as a data character between the two control characters.
- A wrong data lock shows as `out_data` changing under back-pressure.

Each scenario logs every accepted transfer and compares the logged sequence, including the cycle numbers, with the expected one.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {FC_RESUMED = 1'b0, FC_PAUSED = 1'b1} fc_state_e;
  typedef enum logic {MSG_RESUME = 1'b0, MSG_PAUSE = 1'b1} fc_msg_e;
endpackage

// File: rtl/fc_level_cmp.sv
module fc_level_cmp #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             above,
  output logic             below
);
  always_comb begin
    above = level > thresh;
    below = level < thresh;
  end
endmodule

// File: rtl/fc_msg_seq.sv
module fc_msg_seq
  import fc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      double_mode,
  input  logic      above,
  input  logic      below,
  input  logic      ch_fire,
  output logic      busy,
  output fc_msg_e   kind,
  output logic      idx,
  output fc_state_e state
);
  logic pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= FC_RESUMED;
      busy   <= 1'b0;
      kind   <= MSG_RESUME;
      idx    <= 1'b0;
      pair_q <= 1'b0;
    end else begin
      if (busy) begin
        if (ch_fire) begin
          if (pair_q && !idx) begin
            idx <= 1'b1;
          end else begin
            busy <= 1'b0;
            idx  <= 1'b0;
          end
        end
      end else if (enable) begin
        if (state == FC_RESUMED && above) begin
          busy   <= 1'b1;
          kind   <= MSG_PAUSE;
          idx    <= 1'b0;
          pair_q <= double_mode;
          state  <= FC_PAUSED;
        end else if (state == FC_PAUSED && below) begin
          busy   <= 1'b1;
          kind   <= MSG_RESUME;
          idx    <= 1'b0;
          pair_q <= double_mode;
          state  <= FC_RESUMED;
        end
      end
      if (!enable) state <= FC_RESUMED;
    end
  end
endmodule

// File: rtl/fc_char_pick.sv
module fc_char_pick
  import fc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int MIN_W  = 5
) (
  input  fc_msg_e           kind,
  input  logic              idx,
  input  logic [1:0]        word_len,
  input  logic [CHAR_W-1:0] pause1,
  input  logic [CHAR_W-1:0] pause2,
  input  logic [CHAR_W-1:0] resume1,
  input  logic [CHAR_W-1:0] resume2,
  output logic [CHAR_W-1:0] ch
);
  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] raw;

  genvar b;
  generate
    for (b = 0; b < CHAR_W; b++) begin : g_mask
      if (b < MIN_W) begin : g_fixed
        assign mask[b] = 1'b1;
      end else begin : g_var
        assign mask[b] = (32'(word_len) > (b - MIN_W));
      end
    end
  endgenerate

  always_comb begin
    if (kind == MSG_PAUSE) raw = idx ? pause2 : pause1;
    else                   raw = idx ? resume2 : resume1;
    ch = raw & mask;
  end
endmodule

// File: rtl/fc_tx_arb.sv
module fc_tx_arb #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_req,
  input  logic [CHAR_W-1:0] ctrl_char,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_is_ctrl,
  input  logic              out_ready,
  output logic              ctrl_fire
);
  logic data_lock;
  logic sel_ctrl;

  always_comb begin
    sel_ctrl    = ctrl_req && !data_lock;
    out_valid   = sel_ctrl || tx_valid;
    out_data    = sel_ctrl ? ctrl_char : tx_data;
    out_is_ctrl = sel_ctrl;
    tx_ready    = out_ready && !sel_ctrl;
    ctrl_fire   = sel_ctrl && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   data_lock <= 1'b0;
    else if (out_valid && !out_ready && !sel_ctrl) data_lock <= 1'b1;
    else if (out_ready)                           data_lock <= 1'b0;
  end
endmodule

// File: rtl/fc_xonoff_gen.sv
module fc_xonoff_gen
  import fc_pkg::*;
#(
  parameter int LVL_W  = 8,
  parameter int CHAR_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              double_mode,
  input  logic [1:0]        word_len,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  trigger,
  input  logic [CHAR_W-1:0] xoff_char1,
  input  logic [CHAR_W-1:0] xoff_char2,
  input  logic [CHAR_W-1:0] xon_char1,
  input  logic [CHAR_W-1:0] xon_char2,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_is_ctrl,
  input  logic              out_ready
);
  logic              lvl_above, lvl_below;
  logic              seq_busy, seq_idx, ctrl_fire;
  fc_msg_e           seq_kind;
  fc_state_e         seq_state;
  logic [CHAR_W-1:0] ctrl_char;

  fc_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level(rx_level), .thresh(trigger), .above(lvl_above), .below(lvl_below)
  );

  fc_msg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .double_mode(double_mode),
    .above(lvl_above), .below(lvl_below), .ch_fire(ctrl_fire),
    .busy(seq_busy), .kind(seq_kind), .idx(seq_idx), .state(seq_state)
  );

  fc_char_pick #(.CHAR_W(CHAR_W), .MIN_W(MIN_W)) u_pick (
    .kind(seq_kind), .idx(seq_idx), .word_len(word_len),
    .pause1(xoff_char1), .pause2(xoff_char2),
    .resume1(xon_char1), .resume2(xon_char2), .ch(ctrl_char)
  );

  fc_tx_arb #(.CHAR_W(CHAR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .ctrl_req(seq_busy), .ctrl_char(ctrl_char),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .out_valid(out_valid), .out_data(out_data), .out_is_ctrl(out_is_ctrl),
    .out_ready(out_ready), .ctrl_fire(ctrl_fire)
  );
endmodule

// File: rtl/fc_xonoff_chk.sv
module fc_xonoff_chk #(
  parameter int CHAR_W = 8,
  parameter int MIN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [1:0]        word_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data,
  input logic              out_is_ctrl,
  input logic              seq_busy
);
  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_ctrl));

  a_r7_data_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !out_is_ctrl |=> !out_is_ctrl);

  a_r6_width_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_ctrl && word_len == 2'd0 |-> out_data[CHAR_W-1:MIN_W] == '0);

  a_r9_no_new_msg: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !seq_busy |=> !out_is_ctrl);

  a_r10_ctrl_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !out_is_ctrl);
endmodule

bind fc_xonoff_gen fc_xonoff_chk #(.CHAR_W(CHAR_W), .MIN_W(MIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_is_ctrl(out_is_ctrl), .seq_busy(seq_busy)
);

// File: tb/fc_xonoff_gen_test.sv
`timescale 1ns/1ps
module fc_xonoff_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, double_mode = 1'b0, out_ready = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic [7:0] rx_level = 8'd0, trigger = 8'd32;
  logic [7:0] xoff1 = 8'h13, xoff2 = 8'h14, xon1 = 8'h11, xon2 = 8'h12;
  logic       tx_valid, tx_ready, out_valid, out_is_ctrl;
  logic [7:0] tx_data, out_data;

  int src_taken = 0, src_total = 0;
  int cyc = 0, log_n = 0;
  logic [7:0] log_d [64];
  logic       log_c [64];
  int         log_t [64];
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  assign tx_valid = src_taken < src_total;
  assign tx_data  = 8'hA0 + 8'(src_taken);

  fc_xonoff_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .double_mode(double_mode),
    .word_len(word_len), .rx_level(rx_level), .trigger(trigger),
    .xoff_char1(xoff1), .xoff_char2(xoff2), .xon_char1(xon1), .xon_char2(xon2),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .out_valid(out_valid), .out_data(out_data), .out_is_ctrl(out_is_ctrl),
    .out_ready(out_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) src_taken <= src_taken + 1;
    if (rst_n && out_valid && out_ready && log_n < 64) begin
      log_d[log_n] <= out_data;
      log_c[log_n] <= out_is_ctrl;
      log_t[log_n] <= cyc;
      log_n <= log_n + 1;
    end
    if (cyc == 20000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk_entry(input int i, input logic [7:0] d, input logic c, input string req);
    chk(log_d[i] == d, req, int'(log_d[i]), int'(d));
    chk(log_c[i] == c, req, int'(log_c[i]), int'(c));
  endtask

  task automatic t_reset;
    tick(1);
    chk(out_is_ctrl == 1'b0 && out_valid == 1'b0, "R1", int'({out_valid, out_is_ctrl}), 0);
    chk(tx_ready == 1'b1, "R10", int'(tx_ready), 1);
  endtask

  task automatic t_single;
    int b;
    b = log_n;
    enable = 1; double_mode = 0; word_len = 3; xoff1 = 8'h13; xon1 = 8'h11;
    rx_level = 40; tick(10);
    chk(log_n - b == 1, "R2", log_n - b, 1);
    chk_entry(b, 8'h13, 1'b1, "R2");
    tick(20);
    chk(log_n - b == 1, "R3", log_n - b, 1);
    rx_level = 32; tick(10);
    chk(log_n - b == 1, "R3", log_n - b, 1);
    rx_level = 10; tick(10);
    chk(log_n - b == 2, "R4", log_n - b, 2);
    chk_entry(b + 1, 8'h11, 1'b1, "R4");
    tick(10);
    chk(log_n - b == 2, "R3", log_n - b, 2);
  endtask

  task automatic t_double;
    int b;
    logic [7:0] d0;
    b = log_n; d0 = 8'hA0 + 8'(src_taken);
    double_mode = 1; xoff1 = 8'h93; xoff2 = 8'h94; xon1 = 8'h91; xon2 = 8'h92;
    src_total = src_taken + 3; rx_level = 50;
    tick(1); double_mode = 0;
    tick(10);
    chk(log_n - b == 5, "R5", log_n - b, 5);
    chk_entry(b, d0, 1'b0, "R10");
    chk_entry(b + 1, 8'h93, 1'b1, "R5");
    chk_entry(b + 2, 8'h94, 1'b1, "R5");
    chk(log_t[b + 2] == log_t[b + 1] + 1, "R5", log_t[b + 2], log_t[b + 1] + 1);
    chk_entry(b + 3, d0 + 8'd1, 1'b0, "R7");
    double_mode = 1; rx_level = 5; tick(10);
    chk(log_n - b == 7, "R5", log_n - b, 7);
    chk_entry(b + 5, 8'h91, 1'b1, "R5");
    chk_entry(b + 6, 8'h92, 1'b1, "R5");
    double_mode = 0;
  endtask

  task automatic t_width;
    int b;
    b = log_n; xoff1 = 8'hFF; xon1 = 8'hFF;
    word_len = 0; rx_level = 60; tick(8);
    chk_entry(b, 8'h1F, 1'b1, "R6");
    word_len = 1; rx_level = 3; tick(8);
    chk_entry(b + 1, 8'h3F, 1'b1, "R6");
    word_len = 2; rx_level = 60; tick(8);
    chk_entry(b + 2, 8'h7F, 1'b1, "R6");
    word_len = 3; rx_level = 3; tick(8);
    chk_entry(b + 3, 8'hFF, 1'b1, "R6");
  endtask

  task automatic t_hold_data;
    int b;
    logic [7:0] d0;
    b = log_n; xoff1 = 8'h13; xon1 = 8'h11; d0 = 8'hA0 + 8'(src_taken);
    out_ready = 0; src_total = src_taken + 1; tick(3);
    rx_level = 70; tick(4);
    chk(out_valid && !out_is_ctrl && out_data == d0, "R7", int'(out_data), int'(d0));
    out_ready = 1; tick(6);
    chk(log_n - b == 2, "R7", log_n - b, 2);
    chk_entry(b, d0, 1'b0, "R7");
    chk_entry(b + 1, 8'h13, 1'b1, "R7");
  endtask

  task automatic t_backpressure;
    int b;
    b = log_n; out_ready = 0; rx_level = 8; tick(3);
    chk(out_valid && out_is_ctrl && out_data == 8'h11, "R8", int'(out_data), 8'h11);
    xon1 = 8'h11; tick(5);
    chk(out_valid && out_is_ctrl && out_data == 8'h11, "R8", int'(out_data), 8'h11);
    chk(tx_ready == 1'b0, "R8", int'(tx_ready), 0);
    out_ready = 1; tick(4);
    chk(log_n - b == 1, "R8", log_n - b, 1);
  endtask

  task automatic t_disable;
    int b;
    b = log_n; rx_level = 90; tick(8);
    chk(log_n - b == 1, "R9", log_n - b, 1);
    enable = 0; rx_level = 2; tick(10);
    chk(log_n - b == 1, "R9", log_n - b, 1);
    enable = 1; tick(10);
    chk(log_n - b == 1, "R9", log_n - b, 1);
    enable = 0; rx_level = 90; tick(10);
    chk(log_n - b == 1, "R9", log_n - b, 1);
    enable = 1; tick(8);
    chk(log_n - b == 2, "R9", log_n - b, 2);
    chk_entry(b + 1, 8'h13, 1'b1, "R9");
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    t_reset();
    t_single();
    t_double();
    t_width();
    t_hold_data();
    t_backpressure();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule